// File: doc/BRIEF.md
# Crystal Trigger Primitive Generator

This block sits in the front-end logic of a segmented germanium crystal. Every cycle of the global clock it takes one sample from each of 36 segment channels and one sample from the central contact. Each channel runs a leading-edge discriminator. The discriminator takes the difference between the current sample and the sample a fixed lag earlier and compares it with a programmable threshold. It fires on a rising crossing and then holds off for a programmable number of cycles.

Two outputs follow from the per-channel hits. The fast trigger word has one bit per channel and a free-running timestamp, and it reaches the ports one cycle after the sample. External detectors can use it directly.

The slow trigger record is built over a programmable coincidence window. The window opens on the first hit of any channel. The record holds the map of segments that fired, the index of the earliest segment, a coarse energy estimate from the central contact and the timestamp of the window's first cycle. It is emitted once, as a one-cycle valid pulse.

Top module: `trig_prim_gen`

## Requirements
- R1: While rst_ni is low, every output reads zero: the fast word, the timestamp, the slow valid and all slow record fields.
- R2: fast_ts_o reads 0 after reset and increases by exactly 1 on every rising clock edge.
- R3: For each channel, the difference d(n) = x(n) - x(n-LAG) is formed with the sample history reset to zero. Samples are unsigned and the difference is signed. The channel hits on sample n when d(n) >= thr_i and d(n-1) < thr_i. Channel c < 36 is segment c and bit 36 is the central contact. fast_hit_o shows the hit one cycle after the sample is presented, and fast_any_o is high while any bit is set.
- R4: After a hit on sample n, a channel cannot hit again on samples n+1 to n+H, where H is holdoff_i at the time of the hit.
- R5: A slow window opens on the first fast-word cycle with any bit set and spans max(win_len_i,1) fast-word cycles. While it is open, further hits do not start another window. slow_valid_o pulses for one cycle, one cycle after the window's last fast-word cycle. slow_ts_o carries fast_ts_o of the window's first cycle.
- R6: slow_map_o is the OR of the segment bits (bits 35..0) of the fast words inside the window.
- R7: slow_first_o is the lowest segment index set in the earliest window cycle that has any segment bit set, and slow_first_ok_o is 1. When no segment fired in the window, slow_first_ok_o is 0.
- R8: Let the first central-contact hit in the window fall on fast-word cycle c. slow_energy_o is then the contact's difference d on the sample shown at cycle c + e_dly_i, and slow_energy_ok_o is 1. When that cycle falls outside the window, or the contact did not fire, slow_energy_ok_o is 0 and slow_energy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_smp_i | input | N_SEG*SMP_W | Segment samples, segment c in bits [c*SMP_W +: SMP_W] |
| core_smp_i | input | SMP_W | Central contact sample |
| thr_i | input | SMP_W | Discriminator threshold on the lagged difference |
| holdoff_i | input | HO_W | Re-arm hold-off in cycles |
| win_len_i | input | WIN_W | Coincidence window length in fast-word cycles |
| e_dly_i | input | ED_W | Energy sampling delay after the contact hit |
| fast_hit_o | output | N_SEG+1 | Per-channel hit flags, bit N_SEG is the contact |
| fast_any_o | output | 1 | Any channel hit this cycle |
| fast_ts_o | output | TS_W | Timestamp for the fast word |
| slow_valid_o | output | 1 | Slow record valid pulse |
| slow_map_o | output | N_SEG | Segments over threshold in the window |
| slow_first_o | output | $clog2(N_SEG) | Index of earliest segment |
| slow_first_ok_o | output | 1 | Some segment fired |
| slow_energy_o | output | SMP_W+1 | Signed contact difference estimate |
| slow_energy_ok_o | output | 1 | Energy estimate captured |
| slow_ts_o | output | TS_W | Timestamp of the window's first cycle |

## Verification
A history register that is wrong, or a hold-off counter that is stuck, shows up in the fast word one cycle after the sample it corrupts, as a missing, extra or repeated hit bit. Faults in the window state surface only when the record is emitted. A wrong cycle count moves the valid pulse. A first-segment latch that is wrong shows as an index that is not the lowest set bit of the earliest crossing. A delay counter that is off by one gives an energy taken from a neighbouring sample, which differs because the stimulus steps are sized so that neighbouring differences are distinct. The reference model steps on every edge, so each of these is reported within one window length plus one cycle.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;
endpackage

// File: rtl/tpg_lag_diff.sv
module tpg_lag_diff #(
  parameter int SMP_W = 14,
  parameter int LAG   = 4,
  localparam int DW   = SMP_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SMP_W-1:0]     smp_i,
  output logic signed [DW-1:0] diff_o
);
  logic [SMP_W-1:0] hist_q [LAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAG; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= smp_i;
      for (int i = 1; i < LAG; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  assign diff_o = $signed({1'b0, smp_i}) - $signed({1'b0, hist_q[LAG-1]});
endmodule

// File: rtl/tpg_edge_arm.sv
module tpg_edge_arm #(
  parameter int SMP_W = 14,
  parameter int HO_W  = 8,
  localparam int DW   = SMP_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] diff_i,
  input  logic [SMP_W-1:0]     thr_i,
  input  logic [HO_W-1:0]      holdoff_i,
  output logic                 hit_o
);
  logic            above, above_q, fire;
  logic [HO_W-1:0] hold_q;

  assign above = diff_i >= $signed({1'b0, thr_i});
  assign fire  = above && !above_q && (hold_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_q <= 1'b0;
      hold_q  <= '0;
      hit_o   <= 1'b0;
    end else begin
      above_q <= above;
      hit_o   <= fire;
      if (fire)              hold_q <= holdoff_i;
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end
  end
endmodule

// File: rtl/tpg_first_sel.sv
module tpg_first_sel #(
  parameter int N     = 36,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpg_slow_rec.sv
module tpg_slow_rec
  import tpg_pkg::*;
#(
  parameter int N_SEG = 36,
  parameter int SMP_W = 14,
  parameter int TS_W  = 32,
  parameter int WIN_W = 8,
  parameter int ED_W  = 6,
  localparam int IDX_W = $clog2(N_SEG),
  localparam int DW    = SMP_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SEG-1:0]     seg_hit_i,
  input  logic                 core_hit_i,
  input  logic signed [DW-1:0] core_diff_i,
  input  logic [TS_W-1:0]      ts_i,
  input  logic [WIN_W-1:0]     win_len_i,
  input  logic [ED_W-1:0]      e_dly_i,
  output logic                 valid_o,
  output logic [N_SEG-1:0]     map_o,
  output logic [IDX_W-1:0]     first_o,
  output logic                 first_ok_o,
  output logic signed [DW-1:0] energy_o,
  output logic                 energy_ok_o,
  output logic [TS_W-1:0]      ts_o
);
  win_state_e          st_q;
  logic [WIN_W-1:0]    cnt_q, cnt_n;
  logic [N_SEG-1:0]    map_q, map_n;
  logic [IDX_W-1:0]    first_q, first_n, enc_idx;
  logic                fok_q, fok_n, enc_any;
  logic                seen_q, seen_n, got_q, got_n;
  logic [ED_W-1:0]     ecnt_q, ecnt_n;
  logic signed [DW-1:0] en_q, en_n;
  logic [TS_W-1:0]     wts_q, wts_n;
  logic                is_open, active, closing, core_new, cap_now, seen_b, got_b;

  tpg_first_sel #(.N(N_SEG)) u_first (
    .vec_i (seg_hit_i),
    .idx_o (enc_idx),
    .any_o (enc_any)
  );

  always_comb begin
    is_open  = (st_q == WIN_OPEN);
    active   = is_open || enc_any || core_hit_i;
    cnt_n    = is_open ? cnt_q + 1'b1 : WIN_W'(1);
    closing  = active && (cnt_n >= win_len_i);
    map_n    = (is_open ? map_q : '0) | seg_hit_i;
    fok_n    = (is_open && fok_q) || enc_any;
    first_n  = (is_open && fok_q) ? first_q : enc_idx;
    wts_n    = is_open ? wts_q : ts_i;
    seen_b   = is_open && seen_q;
    got_b    = is_open && got_q;
    core_new = core_hit_i && !seen_b;
    // capture on the hit itself for zero delay, else when the countdown ends
    cap_now  = (core_new && (e_dly_i == '0)) ||
               (seen_b && !got_b && (ecnt_q == ED_W'(1)));
    en_n     = cap_now ? core_diff_i : en_q;
    got_n    = got_b || cap_now;
    seen_n   = seen_b || core_hit_i;
    if (core_new)           ecnt_n = e_dly_i;
    else if (ecnt_q != '0)  ecnt_n = ecnt_q - 1'b1;
    else                    ecnt_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= WIN_IDLE;
      cnt_q       <= '0;
      map_q       <= '0;
      first_q     <= '0;
      fok_q       <= 1'b0;
      seen_q      <= 1'b0;
      got_q       <= 1'b0;
      ecnt_q      <= '0;
      en_q        <= '0;
      wts_q       <= '0;
      valid_o     <= 1'b0;
      map_o       <= '0;
      first_o     <= '0;
      first_ok_o  <= 1'b0;
      energy_o    <= '0;
      energy_ok_o <= 1'b0;
      ts_o        <= '0;
    end else begin
      valid_o <= 1'b0;
      if (active) begin
        cnt_q   <= cnt_n;
        map_q   <= map_n;
        first_q <= first_n;
        fok_q   <= fok_n;
        seen_q  <= seen_n;
        got_q   <= got_n;
        ecnt_q  <= ecnt_n;
        en_q    <= en_n;
        wts_q   <= wts_n;
        st_q    <= closing ? WIN_IDLE : WIN_OPEN;
      end
      if (closing) begin
        valid_o     <= 1'b1;
        map_o       <= map_n;
        first_o     <= fok_n ? first_n : '0;
        first_ok_o  <= fok_n;
        energy_o    <= got_n ? en_n : '0;
        energy_ok_o <= got_n;
        ts_o        <= wts_n;
      end
    end
  end
endmodule

// File: rtl/trig_prim_gen.sv
module trig_prim_gen #(
  parameter int N_SEG = 36,
  parameter int SMP_W = 14,
  parameter int LAG   = 4,
  parameter int TS_W  = 32,
  parameter int HO_W  = 8,
  parameter int WIN_W = 8,
  parameter int ED_W  = 6,
  localparam int IDX_W = $clog2(N_SEG),
  localparam int N_CH  = N_SEG + 1,
  localparam int DW    = SMP_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SEG*SMP_W-1:0] seg_smp_i,
  input  logic [SMP_W-1:0]       core_smp_i,
  input  logic [SMP_W-1:0]       thr_i,
  input  logic [HO_W-1:0]        holdoff_i,
  input  logic [WIN_W-1:0]       win_len_i,
  input  logic [ED_W-1:0]        e_dly_i,
  output logic [N_CH-1:0]        fast_hit_o,
  output logic                   fast_any_o,
  output logic [TS_W-1:0]        fast_ts_o,
  output logic                   slow_valid_o,
  output logic [N_SEG-1:0]       slow_map_o,
  output logic [IDX_W-1:0]       slow_first_o,
  output logic                   slow_first_ok_o,
  output logic signed [DW-1:0]   slow_energy_o,
  output logic                   slow_energy_ok_o,
  output logic [TS_W-1:0]        slow_ts_o
);
  logic [N_CH-1:0]      hit;
  logic signed [DW-1:0] core_diff, core_diff_q;
  logic [TS_W-1:0]      ts_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SMP_W-1:0]     smp;
    logic signed [DW-1:0] diff;
    if (c < N_SEG) begin : g_seg
      assign smp = seg_smp_i[c*SMP_W +: SMP_W];
    end else begin : g_core
      assign smp       = core_smp_i;
      assign core_diff = diff;
    end
    tpg_lag_diff #(.SMP_W(SMP_W), .LAG(LAG)) u_lag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp),
      .diff_o (diff)
    );
    tpg_edge_arm #(.SMP_W(SMP_W), .HO_W(HO_W)) u_arm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .diff_i    (diff),
      .thr_i     (thr_i),
      .holdoff_i (holdoff_i),
      .hit_o     (hit[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q        <= '0;
      core_diff_q <= '0;
    end else begin
      ts_q        <= ts_q + 1'b1;
      core_diff_q <= core_diff;
    end
  end

  assign fast_hit_o = hit;
  assign fast_any_o = |hit;
  assign fast_ts_o  = ts_q;

  tpg_slow_rec #(
    .N_SEG(N_SEG), .SMP_W(SMP_W), .TS_W(TS_W), .WIN_W(WIN_W), .ED_W(ED_W)
  ) u_slow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .seg_hit_i   (hit[N_SEG-1:0]),
    .core_hit_i  (hit[N_SEG]),
    .core_diff_i (core_diff_q),
    .ts_i        (ts_q),
    .win_len_i   (win_len_i),
    .e_dly_i     (e_dly_i),
    .valid_o     (slow_valid_o),
    .map_o       (slow_map_o),
    .first_o     (slow_first_o),
    .first_ok_o  (slow_first_ok_o),
    .energy_o    (slow_energy_o),
    .energy_ok_o (slow_energy_ok_o),
    .ts_o        (slow_ts_o)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int N_SEG = 36,
  parameter int TS_W  = 32,
  localparam int IDX_W = $clog2(N_SEG)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SEG:0]   fast_hit_o,
  input logic [TS_W-1:0]  fast_ts_o,
  input logic             slow_valid_o,
  input logic [N_SEG-1:0] slow_map_o,
  input logic [IDX_W-1:0] slow_first_o,
  input logic             slow_first_ok_o,
  input logic [TS_W-1:0]  slow_ts_o
);
  a_r2_ts_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> fast_ts_o == TS_W'($past(fast_ts_o) + 1'b1));

  for (genvar g = 0; g <= N_SEG; g++) begin : g_edge
    a_r3_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fast_hit_o[g] |=> !fast_hit_o[g]);
  end

  a_r5_ts_before_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_valid_o |-> slow_ts_o < fast_ts_o);

  a_r7_first_in_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_valid_o && slow_first_ok_o) |-> slow_map_o[slow_first_o]);

  a_r7_ok_matches_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_valid_o |-> (slow_first_ok_o == (|slow_map_o)));
endmodule

bind trig_prim_gen tpg_checker #(.N_SEG(N_SEG), .TS_W(TS_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fast_hit_o      (fast_hit_o),
  .fast_ts_o       (fast_ts_o),
  .slow_valid_o    (slow_valid_o),
  .slow_map_o      (slow_map_o),
  .slow_first_o    (slow_first_o),
  .slow_first_ok_o (slow_first_ok_o),
  .slow_ts_o       (slow_ts_o)
);

// File: tb/trig_prim_gen_bench.sv
module trig_prim_gen_bench;
  localparam int NS = 36, NC = 37, SW = 14, LG = 4, BASE = 100;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NS*SW-1:0] seg_smp_i;
  logic [SW-1:0] core_smp_i, thr_i;
  logic [7:0] holdoff_i, win_len_i;
  logic [5:0] e_dly_i;
  logic [NC-1:0] fast_hit_o;
  logic fast_any_o, slow_valid_o, slow_first_ok_o, slow_energy_ok_o;
  logic [31:0] fast_ts_o, slow_ts_o;
  logic [NS-1:0] slow_map_o;
  logic [5:0] slow_first_o;
  logic signed [SW:0] slow_energy_o;

  int smp [NC];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R3";

  always #10 clk_i = ~clk_i;

  always_comb begin
    for (int c = 0; c < NS; c++) seg_smp_i[c*SW +: SW] = SW'(smp[c]);
    core_smp_i = SW'(smp[NS]);
  end

  trig_prim_gen u_trig_prim_gen (.*);

  // reference model state
  int m_hist [NC][LG];
  bit m_abp [NC];
  int m_hold [NC];
  bit [NC-1:0] m_hit;
  int m_diff [NC];
  longint m_ts;
  bit w_open, w_fok, w_eok;
  int w_k, w_core_k, w_first, w_en;
  longint w_ts;
  bit [NS-1:0] w_map;
  bit e_sv, e_fok, e_eok;
  bit [NS-1:0] e_map;
  int e_first, e_en;
  longint e_ts;

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < LG; i++) m_hist[c][i] = 0;
      m_abp[c] = 0; m_hold[c] = 0; m_diff[c] = 0;
    end
    m_hit = '0; m_ts = 0; w_open = 0; e_sv = 0; e_map = '0;
    e_first = 0; e_fok = 0; e_eok = 0; e_en = 0; e_ts = 0;
  endtask

  task automatic model_step();
    int wl;
    bit [NS-1:0] segs;
    segs = m_hit[NS-1:0];
    wl = (win_len_i == 0) ? 1 : int'(win_len_i);
    e_sv = 0;
    if (!w_open && m_hit != '0) begin
      w_open = 1; w_k = 0; w_map = '0; w_fok = 0; w_core_k = -1;
      w_eok = 0; w_en = 0; w_ts = m_ts;
    end
    if (w_open) begin
      w_k++;
      w_map |= segs;
      if (!w_fok && segs != '0) begin
        for (int i = NS - 1; i >= 0; i--) if (segs[i]) w_first = i;
        w_fok = 1;
      end
      if (w_core_k < 0 && m_hit[NS]) w_core_k = w_k;
      if (w_core_k >= 0 && !w_eok && w_k == w_core_k + int'(e_dly_i)) begin
        w_en = m_diff[NS]; w_eok = 1;
      end
      if (w_k >= wl) begin
        e_sv = 1; e_map = w_map; e_fok = w_fok; e_first = w_fok ? w_first : 0;
        e_eok = w_eok; e_en = w_eok ? w_en : 0; e_ts = w_ts; w_open = 0;
      end
    end
    for (int c = 0; c < NC; c++) begin
      int d;
      bit ab, f;
      d = smp[c] - m_hist[c][LG-1];
      ab = d >= int'(thr_i);
      f = ab && !m_abp[c] && m_hold[c] == 0;
      if (f) m_hold[c] = int'(holdoff_i);
      else if (m_hold[c] > 0) m_hold[c]--;
      m_abp[c] = ab;
      m_hit[c] = f;
      m_diff[c] = d;
      for (int i = LG - 1; i > 0; i--) m_hist[c][i] = m_hist[c][i-1];
      m_hist[c][0] = smp[c];
    end
    m_ts++;
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) model_reset();
    else model_step();
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string r1;
    r1 = !rst_ni ? "R1" : "";
    chk(r1 == "" ? tag : r1, "fast_hit", longint'(fast_hit_o), longint'(m_hit));
    chk(r1 == "" ? "R3" : r1, "fast_any", fast_any_o, |m_hit);
    chk(r1 == "" ? "R2" : r1, "fast_ts", fast_ts_o, m_ts);
    chk(r1 == "" ? "R5" : r1, "slow_valid", slow_valid_o, e_sv);
    if (!rst_ni) begin
      chk("R1", "slow_map", longint'(slow_map_o), 0);
      chk("R1", "slow_energy", slow_energy_o, 0);
    end
    if (rst_ni && e_sv) begin
      chk("R5", "slow_ts", slow_ts_o, e_ts);
      chk("R6", "slow_map", longint'(slow_map_o), longint'(e_map));
      chk("R7", "slow_first_ok", slow_first_ok_o, e_fok);
      chk("R7", "slow_first", slow_first_o, e_first);
      chk("R8", "slow_energy_ok", slow_energy_ok_o, e_eok);
      chk("R8", "slow_energy", int'(slow_energy_o), e_en);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk_i);
      compare();
    end
  endtask

  task automatic setall(int v);
    for (int c = 0; c < NC; c++) smp[c] = v;
  endtask

  initial begin
    setall(BASE);
    thr_i = 200; holdoff_i = 6; win_len_i = 10; e_dly_i = 3;
    tick(5);
    rst_ni = 1'b1;
    tick(10);
    // single segment
    smp[7] = BASE + 800; tick(20); setall(BASE); tick(12);
    // same-cycle tie, lowest wins (R7)
    smp[12] = BASE + 600; smp[4] = BASE + 700; tick(20); setall(BASE); tick(12);
    // earlier higher index beats later lower index (R7)
    smp[20] = BASE + 500; tick(2); smp[3] = BASE + 900; tick(20); setall(BASE); tick(12);
    // core with energy delay; staircase gives distinct neighbour differences (R8)
    smp[NS] = BASE + 300; tick(1); smp[NS] = BASE + 700; smp[30] = BASE + 400; tick(1);
    smp[NS] = BASE + 1200; tick(1); smp[NS] = BASE + 1800; tick(20); setall(BASE); tick(12);
    // energy delay beyond window, core only (R8, R7)
    e_dly_i = 15; smp[NS] = BASE + 1000; tick(20); setall(BASE); tick(12);
    // minimum window and zero delay (R5, R8)
    win_len_i = 0; e_dly_i = 0; smp[NS] = BASE + 450; smp[35] = BASE + 450; tick(6);
    setall(BASE); tick(8);
    win_len_i = 1; smp[0] = BASE + 250; tick(1); smp[1] = BASE + 250; tick(6);
    setall(BASE); tick(10);
    // hold-off (R4)
    tag = "R4"; win_len_i = 10; e_dly_i = 2; holdoff_i = 6;
    smp[5] = BASE + 900; tick(2); smp[5] = BASE; tick(1); smp[5] = BASE + 900; tick(2);
    smp[5] = BASE; tick(6); smp[5] = BASE + 900; tick(6); setall(BASE); tick(12);
    holdoff_i = 0;
    smp[5] = BASE + 900; tick(2); smp[5] = BASE; tick(1); smp[5] = BASE + 900; tick(6);
    setall(BASE); tick(12);
    tag = "R3";
    // random traffic across parameter sets
    for (int blk = 0; blk < 6; blk++) begin
      win_len_i = 8'(2 + 3 * blk); e_dly_i = 6'(blk * 2); holdoff_i = 8'(blk * 3);
      thr_i = SW'(150 + 60 * blk);
      for (int cyc = 0; cyc < 400; cyc++) begin
        for (int c = 0; c < NC; c++)
          if ($urandom_range(0, 39) == 0)
            smp[c] = (smp[c] == BASE) ? BASE + int'($urandom_range(100, 3000)) : BASE;
        tick(1);
      end
      setall(BASE); tick(30);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule